// File: doc/BRIEF.md
# Split-Join Reduction Stream Network

This block takes one stream of 32-bit words and reduces it in parallel. A distributor deals the incoming words out to four reduction lanes in runs of eight: the first eight words go to lane 0, the next eight to lane 1, and so on, wrapping back to lane 0 after lane 3. Each lane adds up the eight words of its run and emits one sum. A collector then takes one sum from each lane in turn, starting at lane 0. The output stream is therefore the sum of every group of eight consecutive input words, in input order.

Every link in the network is a small FIFO channel with a valid/ready handshake. Every stage starts running at reset and acts as soon as its input holds data and its output has room. A stage that cannot go on waits, so backpressure from the output travels back to the input without losing a word. One word crosses any handshake per clock cycle.

Top module: `sjadd_net`

## Requirements
- R1: Input word number k (counting accepted words from 0 after reset) is routed to lane (k / 8) mod 4.
- R2: Each lane consumes exactly eight words per result and produces their sum as a single output word.
- R3: Output word number j equals the sum of accepted input words 8j through 8j+7, so results leave in lane order 0, 1, 2, 3 and then repeat.
- R4: Sums wrap modulo 2^32. For example, eight words of 0xFFFFFFFF give 0xFFFFFFF8.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value on the next cycle.
- R6: A word is taken only on a cycle where both `in_valid` and `in_ready` are high. When the output is stalled long enough, `in_ready` falls. No word is skipped or duplicated across such stalls.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: An incomplete group produces no output. After only seven words of a group, `out_valid` stays low however long the network is left idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Network accepts the input word this cycle |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Group sum present |
| out_ready | input | 1 | Consumer takes the sum this cycle |
| out_data | output | 32 | Sum of one group of eight input words |

## Verification
The bench drives several data patterns: ascending values, all-ones words that force wrap-around, hashed values, and alternating sign extremes. It combines them with input gaps and several output-stall patterns, including one long stall that must push backpressure all the way to `in_ready`. A distributor that lost its lane or count position during a stall would skip or repeat words, and the group sums would then mismatch. A collector rotating in the wrong order would output correct sums in the wrong positions. Adder width errors show up on the all-ones pattern. A lane that fired early would raise `out_valid` while a group stands at seven words.

// File: rtl/sjadd_pkg.sv
package sjadd_pkg;
    localparam int unsigned SJ_DATA_W = 32;
    localparam int unsigned SJ_LANES  = 4;
    localparam int unsigned SJ_GROUP  = 8;
    localparam int unsigned SJ_DEPTH  = 2;

    // width of an index able to address n items, never zero
    function automatic int unsigned sj_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sjadd_fifo.sv
module sjadd_fifo
    import sjadd_pkg::*;
#(
    parameter int unsigned W     = SJ_DATA_W,
    parameter int unsigned DEPTH = SJ_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int unsigned AW = sj_bits(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          full;
        logic          empty;
    } fifo_st_t;

    fifo_st_t      s_d, s_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          push, pop;

    assign in_ready  = !s_q.full;
    assign out_valid = !s_q.empty;
    assign out_data  = mem_q[s_q.rp];
    assign push      = in_valid && !s_q.full;
    assign pop       = out_ready && !s_q.empty;

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        if (pop)  s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        s_d.full  = (s_d.cnt == CW'(DEPTH));
        s_d.empty = (s_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= in_data;
    end
endmodule

// File: rtl/sjadd_split.sv
module sjadd_split
    import sjadd_pkg::*;
#(
    parameter int unsigned W     = SJ_DATA_W,
    parameter int unsigned LANES = SJ_LANES,
    parameter int unsigned GROUP = SJ_GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_data,
    output logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] lane_ready,
    output logic [W-1:0]     lane_data
);
    localparam int unsigned IW = sj_bits(LANES);
    localparam int unsigned CW = sj_bits(GROUP);

    typedef struct packed {
        logic [IW-1:0] lane;
        logic [CW-1:0] cnt;
    } split_st_t;

    split_st_t s_d, s_q;
    logic      fire;

    assign in_ready  = lane_ready[s_q.lane];
    assign lane_data = in_data;
    assign fire      = in_valid && in_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_valid[i] = in_valid && (s_q.lane == IW'(i));
        end
    end

    // position is only advanced on an accepted word, so stalls keep it
    always_comb begin
        s_d = s_q;
        if (fire) begin
            if (s_q.cnt == CW'(GROUP - 1)) begin
                s_d.cnt  = '0;
                s_d.lane = (s_q.lane == IW'(LANES - 1)) ? '0 : s_q.lane + 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sjadd_accum.sv
module sjadd_accum
    import sjadd_pkg::*;
#(
    parameter int unsigned W     = SJ_DATA_W,
    parameter int unsigned GROUP = SJ_GROUP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int unsigned CW = sj_bits(GROUP);

    typedef struct packed {
        logic [W-1:0]  sum;
        logic [CW-1:0] cnt;
        logic [W-1:0]  res;
        logic          hold;
    } acc_st_t;

    acc_st_t s_d, s_q;

    assign in_ready  = !s_q.hold;
    assign out_valid = s_q.hold;
    assign out_data  = s_q.res;

    always_comb begin
        s_d = s_q;
        if (s_q.hold && out_ready) s_d.hold = 1'b0;
        if (in_valid && !s_q.hold) begin
            if (s_q.cnt == CW'(GROUP - 1)) begin
                s_d.res  = s_q.sum + in_data;
                s_d.hold = 1'b1;
                s_d.sum  = '0;
                s_d.cnt  = '0;
            end else begin
                s_d.sum = s_q.sum + in_data;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sjadd_join.sv
module sjadd_join
    import sjadd_pkg::*;
#(
    parameter int unsigned W     = SJ_DATA_W,
    parameter int unsigned LANES = SJ_LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_valid,
    output logic [LANES-1:0]         lane_ready,
    input  logic [LANES-1:0][W-1:0]  lane_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [W-1:0]             out_data
);
    localparam int unsigned IW = sj_bits(LANES);

    typedef struct packed {
        logic [IW-1:0] lane;
    } join_st_t;

    join_st_t s_d, s_q;

    assign out_valid = lane_valid[s_q.lane];
    assign out_data  = lane_data[s_q.lane];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_ready[i] = out_ready && (s_q.lane == IW'(i));
        end
    end

    always_comb begin
        s_d = s_q;
        if (out_valid && out_ready) begin
            s_d.lane = (s_q.lane == IW'(LANES - 1)) ? '0 : s_q.lane + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sjadd_net.sv
module sjadd_net
    import sjadd_pkg::*;
#(
    parameter int unsigned DATA_W = SJ_DATA_W,
    parameter int unsigned LANES  = SJ_LANES,
    parameter int unsigned GROUP  = SJ_GROUP,
    parameter int unsigned DEPTH  = SJ_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic [LANES-1:0]              split_valid, split_ready;
    logic [DATA_W-1:0]             split_data;
    logic [LANES-1:0]              acc_in_valid, acc_in_ready;
    logic [LANES-1:0][DATA_W-1:0]  acc_in_data;
    logic [LANES-1:0]              acc_out_valid, acc_out_ready;
    logic [LANES-1:0][DATA_W-1:0]  acc_out_data;
    logic [LANES-1:0]              join_valid, join_ready;
    logic [LANES-1:0][DATA_W-1:0]  join_data;

    sjadd_split #(.W(DATA_W), .LANES(LANES), .GROUP(GROUP)) u_split (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .lane_valid(split_valid), .lane_ready(split_ready), .lane_data(split_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sjadd_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fin (
            .clk(clk), .rst_n(rst_n),
            .in_valid(split_valid[g]), .in_ready(split_ready[g]), .in_data(split_data),
            .out_valid(acc_in_valid[g]), .out_ready(acc_in_ready[g]), .out_data(acc_in_data[g])
        );
        sjadd_accum #(.W(DATA_W), .GROUP(GROUP)) u_acc (
            .clk(clk), .rst_n(rst_n),
            .in_valid(acc_in_valid[g]), .in_ready(acc_in_ready[g]), .in_data(acc_in_data[g]),
            .out_valid(acc_out_valid[g]), .out_ready(acc_out_ready[g]), .out_data(acc_out_data[g])
        );
        sjadd_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fout (
            .clk(clk), .rst_n(rst_n),
            .in_valid(acc_out_valid[g]), .in_ready(acc_out_ready[g]), .in_data(acc_out_data[g]),
            .out_valid(join_valid[g]), .out_ready(join_ready[g]), .out_data(join_data[g])
        );
    end

    sjadd_join #(.W(DATA_W), .LANES(LANES)) u_join (
        .clk(clk), .rst_n(rst_n),
        .lane_valid(join_valid), .lane_ready(join_ready), .lane_data(join_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );
endmodule

// File: rtl/sjadd_net_chk.sv
module sjadd_net_chk
    import sjadd_pkg::*;
#(
    parameter int unsigned DATA_W = SJ_DATA_W,
    parameter int unsigned LANES  = SJ_LANES,
    parameter int unsigned GROUP  = SJ_GROUP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  split_valid,
    input logic [LANES-1:0]  join_valid
);
    localparam int unsigned IW = sj_bits(LANES);
    localparam int unsigned CW = sj_bits(GROUP);

    logic [IW-1:0] in_lane_q, out_lane_q;
    logic [CW-1:0] in_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_lane_q  <= '0;
            in_cnt_q   <= '0;
            out_lane_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                if (in_cnt_q == CW'(GROUP - 1)) begin
                    in_cnt_q  <= '0;
                    in_lane_q <= (in_lane_q == IW'(LANES - 1)) ? '0 : in_lane_q + 1'b1;
                end else begin
                    in_cnt_q <= in_cnt_q + 1'b1;
                end
            end
            if (out_valid && out_ready) begin
                out_lane_q <= (out_lane_q == IW'(LANES - 1)) ? '0 : out_lane_q + 1'b1;
            end
        end
    end

    a_r1_route_by_group: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> split_valid[in_lane_q]);

    a_r1_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(split_valid));

    a_r3_join_order: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> join_valid[out_lane_q]);

    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind sjadd_net sjadd_net_chk #(.DATA_W(DATA_W), .LANES(LANES), .GROUP(GROUP)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .split_valid(split_valid), .join_valid(join_valid)
);

// File: tb/sjadd_net_tb.sv
`timescale 1ns/1ps
module sjadd_net_tb;
    localparam int NGRP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    int rcv    = 0;
    int run_pat = 0;
    int sink_mode = 0;
    int sink_cyc = 0;
    bit in_low_seen = 0;
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;

    always #2.5 clk = ~clk;

    sjadd_net u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen(input int pat, input int k);
        case (pat)
            0:       return 32'(k + 1);
            1:       return 32'hFFFF_FFFF;
            2:       return 32'(k) * 32'h9E37_79B1 + 32'h0123_4567;
            default: return (k % 2 == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF + 32'(k);
        endcase
    endfunction

    function automatic logic [31:0] exp_sum(input int pat, input int g);
        logic [31:0] s = '0;
        for (int i = 0; i < 8; i++) s = s + gen(pat, 8 * g + i);
        return s;
    endfunction

    // sink: decides out_ready, then checks the transfer that happens at the next edge
    always @(negedge clk) begin
        if (rst_n) begin
            sink_cyc++;
            if (!in_ready) in_low_seen = 1;
            if (prev_stall) chk(out_valid && out_data == prev_data, "R5 held output", out_data, prev_data);
            case (sink_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (sink_cyc % 3 == 0);
                2:       out_ready = (sink_cyc >= 200);
                default: out_ready = sink_cyc[0];
            endcase
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (rcv < NGRP) begin
                    chk(out_data == exp_sum(run_pat, rcv), (run_pat == 1) ? "R4 wrap sum" : "R3 group sum",
                        out_data, exp_sum(run_pat, rcv));
                end else begin
                    chk(1'b0, "R3 extra output", out_data, 32'h0);
                end
                rcv++;
            end
        end
    end

    task automatic send(input logic [31:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input int pat, input int gap, input int smode, input bit pause);
        run_pat = pat;
        sink_mode = smode;
        sink_cyc = 0;
        rcv = 0;
        in_low_seen = 0;
        for (int k = 0; k < 8 * NGRP; k++) begin
            send(gen(pat, k));
            if (gap != 0 && k % 5 == 2) @(negedge clk);
            if (pause && k == 6) begin
                // R8: seven words of group 0 present, nothing may come out
                repeat (40) @(negedge clk);
                chk(!out_valid && rcv == 0, "R8 partial group", 32'(out_valid), 32'h0);
            end
        end
        while (rcv < NGRP) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(rcv == NGRP, "R2 one result per eight words", 32'(rcv), 32'(NGRP));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R7 out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready, "R7 in_ready after reset", 32'(in_ready), 32'h1);

        run(0, 0, 0, 1'b1);       // R1 R3 R8 ascending values
        run(1, 1, 1, 1'b0);       // R4 wrap with gaps and slow sink
        run(2, 1, 2, 1'b0);       // R6 long output stall
        chk(in_low_seen, "R6 backpressure reached input", 32'(in_low_seen), 32'h1);
        run(3, 0, 3, 1'b0);       // R5 alternating stall
        run(2, 0, 0, 1'b0);       // R1 full rate
        chk(!out_valid, "R2 idle after all groups", 32'(out_valid), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule